// File: doc/BRIEF.md
# Split-Clock Counting Presence Filter

This block answers, in one fast-clock cycle, whether a line address might be held in an inclusive cache. Each address is folded by XOR into a table index. A small saturating counter per index records how many resident lines map there. The counters live in a slow clock domain and are driven by cache-side insert and remove events. A one-bit-per-index presence vector lives in the fast domain next to the requester. A query reads only that vector: a zero means the line is certainly absent, and a one means it may be present.

Only changes between zero and nonzero matter to the vector. The slow side sends each such change, together with its index and new bit value, through a small gray-pointer asynchronous FIFO. Inserts are meant to be issued when a miss is detected rather than when the fill completes. The set therefore reaches the vector before the data can arrive. A late clear only produces an extra normal cache access.

A counter that overflows is frozen with its presence bit held at one. When a set number of counters have frozen, the block raises a one-cycle flush request. The acknowledge wipes every counter, every freeze flag and the whole presence vector.

Top module: `seg_presence_filter`

## Requirements
- R1: After reset every query returns 0 and `flush_req` is low.
- R2: The index is the XOR of the address cut into IDX_W-bit slices starting at bit 0, with the top slice zero-padded (IDX_W=10, ADDR_W=32 by default).
- R3: `q_present` is registered: it shows the presence bit for the `q_addr` sampled at the previous `clk_fast` edge.
- R4: An increment on a counter holding 0 makes the presence bit 1, visible to queries within 8 `clk_fast` cycles after the `clk_slow` edge.
- R5: A decrement taking a counter from 1 to 0 clears the presence bit. A decrement from a higher value leaves it at 1.
- R6: An increment and a decrement whose addresses hash to the same index in the same `clk_slow` cycle leave that counter unchanged.
- R7: A decrement on a counter holding 0 is ignored, and the counter stays 0.
- R8: An increment on a counter holding 7 (the 3-bit maximum) freezes it. A frozen counter ignores increments and decrements, and its presence bit stays 1.
- R9: When the number of frozen counters reaches SAT_LIMIT (default 4), `flush_req` is high for exactly one `clk_slow` cycle, following the edge that froze the last one.
- R10: `flush_ack` clears all counters, freeze flags and presence bits. Increments and decrements presented in the same cycle are dropped.
- R11: An increment and a decrement on different indices in the same `clk_slow` cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Query-side clock |
| rst_fast_n | input | 1 | Active-low reset, fast domain |
| q_addr | input | ADDR_W | Address to look up |
| q_present | output | 1 | 1 = may be present, 0 = certainly absent |
| clk_slow | input | 1 | Counter-side clock |
| rst_slow_n | input | 1 | Active-low reset, slow domain |
| inc_v | input | 1 | Insert event valid |
| inc_addr | input | ADDR_W | Insert address |
| dec_v | input | 1 | Remove event valid |
| dec_addr | input | ADDR_W | Remove address |
| flush_ack | input | 1 | Clears the whole filter |
| flush_req | output | 1 | One-cycle pulse when the freeze count reaches its limit |

## Verification
The hardest state to reach is the flush condition. It needs several separate counters driven past their 3-bit maximum with no intervening removes, and the vector must be observed only after the cross-domain update has drained. The directed part drives eight inserts into each of four chosen indices, then checks the pulse, that frozen bits stick, and the wipe on acknowledge. Random addresses are built to land on a small set of indices by solving the fold for the low slice, so collisions, cancellations and further freezes occur often.

// File: rtl/spf_pkg.sv
package spf_pkg;
  parameter int CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

  // counter arithmetic: one step up or down
  function automatic cnt_t cnt_step(input cnt_t c, input logic up);
    return up ? cnt_t'(c + 1'b1) : cnt_t'(c - 1'b1);
  endfunction

  // saturation counter arithmetic
  function automatic int unsigned sat_bump(input int unsigned c, input int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction
endpackage

// File: rtl/spf_hash.sv
module spf_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  // each address bit folds onto index bit (position mod IDX_W)
  function automatic logic [IDX_W-1:0] fold(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < ADDR_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ a[i];
    return h;
  endfunction

  assign idx = fold(addr);
endmodule

// File: rtl/spf_xfifo.sv
module spf_xfifo #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd,
  output logic         rvalid,
  output logic [W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [AW:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [AW:0] r2w_s1, r2w_s2, w2r_s1, w2r_s2;
  logic [AW:0] wbin_nx, rbin_nx;
  logic        do_wr, do_rd;

  assign full    = (wgray_q == {~r2w_s2[AW:AW-1], r2w_s2[AW-2:0]});
  assign rvalid  = (rgray_q != w2r_s2);
  assign do_wr   = wr && !full;
  assign do_rd   = rd && rvalid;
  assign wbin_nx = wbin_q + 1'b1;
  assign rbin_nx = rbin_q + 1'b1;
  assign rdata   = mem[rbin_q[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (do_wr) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q <= '0; wgray_q <= '0; r2w_s1 <= '0; r2w_s2 <= '0;
    end else begin
      r2w_s1 <= rgray_q;
      r2w_s2 <= r2w_s1;
      if (do_wr) begin
        wbin_q  <= wbin_nx;
        wgray_q <= to_gray(wbin_nx);
      end
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q <= '0; rgray_q <= '0; w2r_s1 <= '0; w2r_s2 <= '0;
    end else begin
      w2r_s1 <= wgray_q;
      w2r_s2 <= w2r_s1;
      if (do_rd) begin
        rbin_q  <= rbin_nx;
        rgray_q <= to_gray(rbin_nx);
      end
    end
  end

  AST_WPTR_ONE_BIT: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R4
  AST_RPTR_ONE_BIT: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1); // R4
endmodule

// File: rtl/spf_count_bank.sv
module spf_count_bank
  import spf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 10,
  parameter int SAT_LIMIT = 4,
  parameter int EV_W      = 1 + 2 * (IDX_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_v,
  input  logic [ADDR_W-1:0] inc_addr,
  input  logic              dec_v,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic              flush_ack,
  output logic              flush_req,
  output logic              ev_wr,
  output logic [EV_W-1:0]   ev_data,
  input  logic              ev_full
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SATC_W  = $clog2(SAT_LIMIT + 1);

  cnt_t               cnt_q [ENTRIES];
  logic [ENTRIES-1:0] frz_q;
  logic [SATC_W-1:0]  satc_q;
  logic               flush_q;

  logic [IDX_W-1:0] inc_idx, dec_idx;
  cnt_t             inc_cur, dec_cur;

  // named internal events for the checks
  logic same_hit, eff_inc, eff_dec, inc_rise, inc_freeze, dec_fall, limit_hit;

  spf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_inc (.addr(inc_addr), .idx(inc_idx));
  spf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_dec (.addr(dec_addr), .idx(dec_idx));

  assign inc_cur    = cnt_q[inc_idx];
  assign dec_cur    = cnt_q[dec_idx];
  assign same_hit   = inc_v && dec_v && (inc_idx == dec_idx);
  assign eff_inc    = inc_v && !same_hit && !flush_ack && !frz_q[inc_idx];
  assign eff_dec    = dec_v && !same_hit && !flush_ack && !frz_q[dec_idx] && (dec_cur != '0);
  assign inc_rise   = eff_inc && (inc_cur == '0);
  assign inc_freeze = eff_inc && (inc_cur == CNT_MAX);
  assign dec_fall   = eff_dec && (dec_cur == cnt_t'(1));
  assign limit_hit  = inc_freeze && (satc_q == SATC_W'(SAT_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= '0;
      frz_q   <= '0;
      satc_q  <= '0;
      flush_q <= 1'b0;
    end else if (flush_ack) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= '0;
      frz_q   <= '0;
      satc_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      if (eff_inc) begin
        if (inc_freeze) frz_q[inc_idx] <= 1'b1;
        else            cnt_q[inc_idx] <= cnt_step(inc_cur, 1'b1);
      end
      if (eff_dec) cnt_q[dec_idx] <= cnt_step(dec_cur, 1'b0);
      if (inc_freeze) satc_q <= SATC_W'(sat_bump(int'(satc_q), SAT_LIMIT));
      flush_q <= limit_hit;
    end
  end

  assign flush_req = flush_q;
  assign ev_wr     = rst_n && (flush_ack || inc_rise || dec_fall);
  assign ev_data   = {flush_ack, inc_rise, inc_idx, 1'b1, dec_fall, dec_idx, 1'b0};

  AST_EV_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> !ev_full); // R4
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req); // R9
  AST_CANCEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (same_hit && !flush_ack) |=> cnt_q[$past(inc_idx)] == $past(inc_cur)); // R6
  AST_DEC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_v && !inc_v && !flush_ack && dec_cur == '0) |=> cnt_q[$past(dec_idx)] == '0); // R7
  AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_ack |=> ((frz_q & $past(frz_q)) == $past(frz_q))); // R8
endmodule

// File: rtl/spf_presence_vec.sv
module spf_presence_vec #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int EV_W   = 1 + 2 * (IDX_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_present,
  input  logic              upd_v,
  input  logic [EV_W-1:0]   upd_data,
  output logic              upd_pop
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] bits_q;
  logic               hit_q;
  logic [IDX_W-1:0]   q_idx, a_idx, b_idx;
  logic               clr_all, a_v, a_bit, b_v, b_bit;

  spf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_q (.addr(q_addr), .idx(q_idx));

  assign {clr_all, a_v, a_idx, a_bit, b_v, b_idx, b_bit} = upd_data;
  assign upd_pop = upd_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      hit_q <= bits_q[q_idx];
      if (upd_v) begin
        if (clr_all) bits_q <= '0;
        else begin
          if (a_v) bits_q[a_idx] <= a_bit;
          if (b_v) bits_q[b_idx] <= b_bit;
        end
      end
    end
  end

  assign q_present = hit_q;

  AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_v && clr_all) |=> (bits_q == '0)); // R10
  AST_SLOT_A_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_v && !clr_all && a_v) |=> bits_q[$past(a_idx)] == $past(a_bit)); // R4
  AST_SLOT_B_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_v && !clr_all && b_v) |=> bits_q[$past(b_idx)] == $past(b_bit)); // R5
endmodule

// File: rtl/seg_presence_filter.sv
module seg_presence_filter #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 10,
  parameter int SAT_LIMIT = 4,
  parameter int FIFO_AW   = 3
) (
  input  logic              clk_fast,
  input  logic              rst_fast_n,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_present,
  input  logic              clk_slow,
  input  logic              rst_slow_n,
  input  logic              inc_v,
  input  logic [ADDR_W-1:0] inc_addr,
  input  logic              dec_v,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic              flush_ack,
  output logic              flush_req
);
  localparam int EV_W = 1 + 2 * (IDX_W + 2);

  logic            ev_wr, ev_full, ev_rvalid, ev_pop;
  logic [EV_W-1:0] ev_wdata, ev_rdata;

  spf_count_bank #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SAT_LIMIT(SAT_LIMIT), .EV_W(EV_W)
  ) u_bank (
    .clk(clk_slow), .rst_n(rst_slow_n),
    .inc_v(inc_v), .inc_addr(inc_addr), .dec_v(dec_v), .dec_addr(dec_addr),
    .flush_ack(flush_ack), .flush_req(flush_req),
    .ev_wr(ev_wr), .ev_data(ev_wdata), .ev_full(ev_full)
  );

  spf_xfifo #(.W(EV_W), .AW(FIFO_AW)) u_xfer (
    .wclk(clk_slow), .wrst_n(rst_slow_n), .wr(ev_wr), .wdata(ev_wdata), .full(ev_full),
    .rclk(clk_fast), .rrst_n(rst_fast_n), .rd(ev_pop), .rvalid(ev_rvalid), .rdata(ev_rdata)
  );

  spf_presence_vec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .EV_W(EV_W)) u_vec (
    .clk(clk_fast), .rst_n(rst_fast_n), .q_addr(q_addr), .q_present(q_present),
    .upd_v(ev_rvalid), .upd_data(ev_rdata), .upd_pop(ev_pop)
  );
endmodule

// File: tb/seg_presence_filter_tb_top.sv
module seg_presence_filter_tb_top;
  localparam int AW = 32;
  localparam int IW = 10;
  localparam int NE = 1 << IW;
  localparam int LIM = 4;

  logic clk_fast = 1'b0, clk_slow = 1'b0;
  logic rst_fast_n = 1'b0, rst_slow_n = 1'b0;
  logic [AW-1:0] q_addr = '0, inc_addr = '0, dec_addr = '0;
  logic inc_v = 1'b0, dec_v = 1'b0, flush_ack = 1'b0;
  logic q_present, flush_req;

  always #4 clk_fast = ~clk_fast;   // 125 MHz
  always #12 clk_slow = ~clk_slow;

  seg_presence_filter dut_i (
    .clk_fast(clk_fast), .rst_fast_n(rst_fast_n), .q_addr(q_addr), .q_present(q_present),
    .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
    .inc_v(inc_v), .inc_addr(inc_addr), .dec_v(dec_v), .dec_addr(dec_addr),
    .flush_ack(flush_ack), .flush_req(flush_req)
  );

  int n_chk = 0, n_bad = 0;
  int m_cnt [NE];
  bit m_frz [NE];
  int m_nfrz = 0;
  bit exp_flush = 0;
  bit flush_owed = 0;

  // slice-wise fold (R2)
  function automatic logic [IW-1:0] bhash(input logic [AW-1:0] a);
    logic [3*IW-1+IW:0] padded;
    logic [IW-1:0] h;
    padded = '0;
    padded[AW-1:0] = a;
    h = '0;
    for (int s = 0; s * IW < AW; s++) h = h ^ padded[s*IW +: IW];
    return h;
  endfunction

  function automatic logic [AW-1:0] addr_for(input int t, input logic [AW-1:0] r);
    logic [AW-1:0] a;
    a = {r[AW-1:IW], {IW{1'b0}}};
    return a | AW'(IW'(t) ^ bhash(a));
  endfunction

  function automatic bit exp_bit(input int i);
    return m_frz[i] || (m_cnt[i] != 0);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic query(input logic [AW-1:0] a, input bit exp, input string req);
    repeat (12) @(posedge clk_fast);
    @(negedge clk_fast) q_addr = a;
    @(posedge clk_fast);
    @(negedge clk_fast);
    check(req, int'(q_present), int'(exp));
  endtask

  task automatic qidx(input int t, input string req);
    query(addr_for(t, $urandom), exp_bit(t), req);
  endtask

  task automatic slow_op(input bit iv, input logic [AW-1:0] ia,
                         input bit dv, input logic [AW-1:0] da, input bit ack);
    int hi, hd;
    bit same;
    @(negedge clk_slow);
    inc_v = iv; inc_addr = ia; dec_v = dv; dec_addr = da; flush_ack = ack;
    @(posedge clk_slow);
    @(negedge clk_slow);
    inc_v = 0; dec_v = 0; flush_ack = 0;
    hi = int'(bhash(ia)); hd = int'(bhash(da));
    same = iv && dv && (hi == hd);
    exp_flush = 0;
    if (ack) begin
      for (int i = 0; i < NE; i++) begin m_cnt[i] = 0; m_frz[i] = 0; end
      m_nfrz = 0; flush_owed = 0;
    end else begin
      if (iv && !same && !m_frz[hi]) begin
        if (m_cnt[hi] == 7) begin
          m_frz[hi] = 1; m_nfrz++;
          if (m_nfrz == LIM) begin exp_flush = 1; flush_owed = 1; end
        end else m_cnt[hi]++;
      end
      if (dv && !same && !m_frz[hd] && m_cnt[hd] > 0) m_cnt[hd]--;
    end
    check("R9 flush_req", int'(flush_req), int'(exp_flush));
  endtask

  initial begin
    repeat (150000) @(posedge clk_fast);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, b;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NE; i++) begin m_cnt[i] = 0; m_frz[i] = 0; end
    #100;
    @(negedge clk_slow) rst_slow_n = 1'b1;
    @(negedge clk_fast) rst_fast_n = 1'b1;

    // R1 reset state
    check("R1 flush_req", int'(flush_req), 0);
    query(32'h0, 0, "R1");
    query(32'hDEAD_BEEF, 0, "R1");

    // R2/R3/R4: insert via one address, look up through another with the same fold
    a = addr_for(5, 32'h1234_5678);
    b = addr_for(5, 32'hABCD_0000);
    slow_op(1, a, 0, 0, 0);
    query(b, 1, "R2 alias");
    query(a, 1, "R4 set");
    query(addr_for(6, 32'h1234_5678), 0, "R3 neighbour");

    // R5: count to 2, remove twice
    slow_op(1, b, 0, 0, 0);
    slow_op(0, 0, 1, a, 0);
    query(a, 1, "R5 still held");
    slow_op(0, 0, 1, b, 0);
    query(a, 0, "R5 cleared");

    // R6: same-index cancel
    slow_op(1, addr_for(7, 32'h1111_0000), 1, addr_for(7, 32'h2222_0000), 0);
    qidx(7, "R6 cancel");
    slow_op(1, addr_for(7, 32'h3333_0000), 0, 0, 0);
    slow_op(0, 0, 1, addr_for(7, 32'h4444_0000), 0);
    qidx(7, "R6 counter was zero");

    // R7: remove on an empty counter, then one insert and one remove
    slow_op(0, 0, 1, addr_for(8, 32'h5555_0000), 0);
    qidx(8, "R7 empty");
    slow_op(1, addr_for(8, 32'h6666_0000), 0, 0, 0);
    qidx(8, "R7 after insert");
    slow_op(0, 0, 1, addr_for(8, 32'h7777_0000), 0);
    qidx(8, "R7 back to zero");

    // R11: different indices in the same cycle
    slow_op(1, addr_for(10, 32'h0), 0, 0, 0);
    slow_op(1, addr_for(11, 32'h0), 1, addr_for(10, 32'h0), 0);
    qidx(10, "R11 dec side");
    qidx(11, "R11 inc side");

    // R8/R9: freeze four counters
    for (int t = 20; t < 24; t++)
      for (int k = 0; k < 8; k++) slow_op(1, addr_for(t, $urandom), 0, 0, 0);
    check("R9 pulse seen", int'(flush_owed), 1);
    for (int k = 0; k < 9; k++) slow_op(0, 0, 1, addr_for(20, $urandom), 0);
    qidx(20, "R8 frozen stays set");
    qidx(23, "R8 frozen stays set");

    // R10: acknowledge with a simultaneous insert
    slow_op(1, addr_for(30, 32'h0), 0, 0, 1);
    qidx(20, "R10 wiped");
    qidx(11, "R10 wiped");
    qidx(30, "R10 insert dropped");

    // random phase over a small index set
    for (int n = 0; n < 300; n++) begin
      int ti, td;
      bit iv, dv, ack;
      ti = 100 + int'($urandom % 16);
      td = 100 + int'($urandom % 16);
      iv = ($urandom % 4) != 0;
      dv = ($urandom % 3) == 0;
      ack = flush_owed && (($urandom % 4) == 0);
      slow_op(iv, addr_for(ti, $urandom), dv, addr_for(td, $urandom), ack);
      qidx(ti, "R4/R5/R8 random");
      qidx(td, "R5/R6/R7 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule